// File: doc/BRIEF.md
# Clocked Serial I/O Transceiver

This block is a full-duplex synchronous serial port that moves eight-bit bytes, least-significant bit first, over a data-out pin and a data-in pin. One buffer holds both directions. The host fills it with the next outgoing byte, and when a byte completes, the incoming byte replaces that content and a one-cycle interrupt pulse is raised. The serial clock is either made inside the block from a divider of the system clock, or taken from an external pin. An external clock and the data-in pin pass through a two-flop synchronizer, and their edges are detected in the system clock domain.

The buffer is reached through two valid/ready streams. The transmit stream is accepted only while the buffer is free, which means the last received byte has been taken. The receive stream offers the buffer while it holds an unread received byte. A value offered on either stream must stay on its port until the handshake completes. With the internal clock, the serial clock stalls high between bytes until the host has read the received byte and written a new one. With the external clock, shifting never waits. If no new byte was written in time, all ones are sent, and a byte that lands on an unread one raises an overrun flag. Lowering the start input lets the byte in progress finish. Pulsing the inhibit input aborts the transfer at once.

Top module: `sio_xcvr`

## Requirements
- R1: After reset, busy, irq, overrun and rx_valid are 0, tx_ready is 1, and sck_o and sdo are 1.
- R2: A byte is shifted out on sdo LSB first and changes on falling sck edges. sdi is sampled on rising edges. After the eighth rising edge the received byte is in the buffer, rx_valid is 1, and irq is high for exactly one cycle.
- R3: In internal mode, each half period of sck_o lasts clk_div+1 system cycles, and sck_o idles high when no byte is shifting.
- R4: In internal mode with start held, once a byte completes, sck_o stays high and busy stays 1 until the received byte is read and a new byte is written.
- R5: From the moment a byte is loaded until its first falling sck edge, sdo keeps the last bit of the previous byte.
- R6: Lowering start during a byte lets that byte finish and reach the buffer, and busy stays 1 until then. Busy then clears, including when start is lowered between bytes.
- R7: Pulsing inhibit clears busy on the next cycle with no irq. A byte in flight is discarded, leaving tx_ready at 1 and rx_valid at 0.
- R8: In external mode, bits move on the synchronized edges of sck_i and no wait is inserted between bytes. Each byte's outgoing data is taken at its first falling edge, and is 8'hFF if no byte was written.
- R9: In external mode, a byte that completes while the previous received byte is unread and not being read sets overrun. Reading the buffer clears overrun.
- R10: If a byte completes in the same cycle as a receive handshake, the old byte is handed over and the new byte stays in the buffer, with rx_valid 1 and overrun 0.
- R11: Changing ext_clk_sel discards the buffer: rx_valid becomes 0, tx_ready becomes 1, and overrun becomes 0.
- R12: tx_data is taken only on tx_valid and tx_ready, and the buffer is freed only on rx_valid and rx_ready. While rx_valid is 1 and rx_ready is 0, rx_data holds unless a new byte completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run enable; lowering it stops after the current byte |
| inhibit | input | 1 | Immediate abort |
| ext_clk_sel | input | 1 | 1 selects the external serial clock |
| clk_div | input | DIV_W | Internal half period minus one, in system cycles |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Buffer free for a transmit byte |
| tx_data | input | DW | Transmit byte |
| rx_valid | output | 1 | Buffer holds an unread received byte |
| rx_ready | input | 1 | Host takes the received byte |
| rx_data | output | DW | Buffer contents |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | One-cycle pulse when a byte completes |
| overrun | output | 1 | External-mode byte landed on an unread byte |
| sck_i | input | 1 | External serial clock |
| sdi | input | 1 | Serial data in |
| sck_o | output | 1 | Internal serial clock, held high in external mode |
| sdo | output | 1 | Serial data out |

## Verification
In external mode, the completion of a byte and a receive handshake can fall on the same system cycle. The bench provokes this by raising the eighth sck_i rising edge and asserting rx_ready exactly two system edges later, so the handshake lands on the edge that stores the byte. It judges the result by checking that the old byte was on rx_data during the handshake, and that afterwards the new byte is held with rx_valid still 1 and overrun still 0. The abort path is also provoked in the middle of a byte, to confirm that no irq follows.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [1:0] {
    BUF_FREE   = 2'd0,
    BUF_TXRDY  = 2'd1,
    BUF_FLIGHT = 2'd2,
    BUF_RXFULL = 2'd3
  } buf_st_e;
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, stab;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= RST_VAL[i];
        stab <= RST_VAL[i];
      end else begin
        meta <= d[i];
        stab <= meta;
      end
    end
    assign q[i] = stab;
  end
endmodule

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             fall,
  output logic             rise
);
  logic [DIV_W-1:0] cnt;
  logic hit;

  always_comb begin
    hit  = run && (cnt == div);
    fall = hit && sck;
    rise = hit && !sck;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b1;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b1;
    end else if (hit) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: clock parks high whenever no byte is shifting
  assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> sck);
endmodule

// File: rtl/sio_engine.sv
module sio_engine #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          inhibit,
  input  logic          ext_mode,
  input  logic          fall,
  input  logic          rise,
  input  logic          sdi,
  input  logic          buf_tx,
  input  logic [DW-1:0] buf_data,
  output logic          load,
  output logic          done,
  output logic [DW-1:0] rx_byte,
  output logic          busy,
  output logic          active,
  output logic          sdo
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [CW-1:0] cnt;
  logic [DW-1:0] tx_sh, rx_sh, first;

  always_comb begin
    first   = buf_tx ? buf_data : '1;
    rx_byte = {sdi, rx_sh[DW-1:1]};
    load    = 1'b0;
    if (!inhibit) begin
      if (!busy)
        load = start && buf_tx;
      else if (!active)
        load = start && buf_tx && (ext_mode ? fall : 1'b1);
    end
    done = !inhibit && busy && active && rise && (cnt == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
      tx_sh  <= '1;
      rx_sh  <= '0;
      sdo    <= 1'b1;
    end else if (inhibit) begin
      busy   <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
    end else if (!busy) begin
      if (load) begin
        busy   <= 1'b1;
        active <= 1'b1;
        tx_sh  <= buf_data;
        cnt    <= '0;
      end
    end else if (!active) begin
      if (!start) begin
        busy <= 1'b0;
      end else if (ext_mode) begin
        if (fall) begin
          active <= 1'b1;
          sdo    <= first[0];
          tx_sh  <= {1'b1, first[DW-1:1]};
          cnt    <= '0;
        end
      end else if (load) begin
        active <= 1'b1;
        tx_sh  <= buf_data;
        cnt    <= '0;
      end
    end else begin
      if (fall) begin
        sdo   <= tx_sh[0];
        tx_sh <= {1'b1, tx_sh[DW-1:1]};
      end
      if (rise) begin
        rx_sh <= rx_byte;
        if (cnt == LAST) begin
          cnt    <= '0;
          active <= 1'b0;
          if (!start) busy <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R5: data-out only moves on a falling serial edge
  assert_sdo_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sdo));
  // R7: abort drops busy on the next cycle
  assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> !busy);
endmodule

// File: rtl/sio_buf.sv
module sio_buf
  import sio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_mode,
  input  logic          inhibit,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  input  logic          rx_ready,
  input  logic          load,
  input  logic          done,
  input  logic [DW-1:0] rx_byte,
  output logic          tx_ready,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  output logic          buf_tx,
  output logic          irq,
  output logic          overrun
);
  buf_st_e st;
  logic [DW-1:0] data;
  logic ext_q, mode_chg, wr, rd;

  always_comb begin
    mode_chg = ext_mode != ext_q;
    tx_ready = st == BUF_FREE;
    rx_valid = st == BUF_RXFULL;
    buf_tx   = st == BUF_TXRDY;
    rx_data  = data;
    wr       = tx_valid && tx_ready;
    rd       = rx_valid && rx_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= BUF_FREE;
      data    <= '0;
      ext_q   <= 1'b0;
      irq     <= 1'b0;
      overrun <= 1'b0;
    end else begin
      ext_q <= ext_mode;
      irq   <= done && !mode_chg;
      if (mode_chg) begin
        st      <= BUF_FREE;
        data    <= '0;
        overrun <= 1'b0;
      end else if (done) begin
        data <= rx_byte;
        st   <= BUF_RXFULL;
        if (st == BUF_RXFULL && !rd) overrun <= 1'b1;
        else if (rd)                 overrun <= 1'b0;
      end else if (inhibit && st == BUF_FLIGHT) begin
        st <= BUF_FREE;
      end else begin
        if (load) st <= BUF_FLIGHT;
        if (rd) begin
          st      <= BUF_FREE;
          overrun <= 1'b0;
        end
        if (wr) begin
          st   <= BUF_TXRDY;
          data <= tx_data;
        end
      end
    end
  end

  // R12: an unread byte holds until taken, replaced or discarded
  assert_rx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !done && !mode_chg) |=> (rx_valid && $stable(rx_data)));
  // R9: overrun can only appear in external mode
  assert_ovr_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> ext_q);
endmodule

// File: rtl/sio_xcvr.sv
module sio_xcvr #(
  parameter int DW    = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             inhibit,
  input  logic             ext_clk_sel,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [DW-1:0]    tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [DW-1:0]    rx_data,
  output logic             busy,
  output logic             irq,
  output logic             overrun,
  input  logic             sck_i,
  input  logic             sdi,
  output logic             sck_o,
  output logic             sdo
);
  logic [1:0] sync_q;
  logic sck_s, sdi_s, sck_prev;
  logic ext_rise, ext_fall, int_rise, int_fall, int_sck;
  logic fall, rise, run, active, load, done, buf_tx;
  logic [DW-1:0] rx_byte;

  sio_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sdi, sck_i}), .q(sync_q));

  assign sck_s = sync_q[0];
  assign sdi_s = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b1;
    else        sck_prev <= sck_s;
  end

  always_comb begin
    ext_rise = sck_s && !sck_prev;
    ext_fall = !sck_s && sck_prev;
    run      = busy && active && !ext_clk_sel;
    fall     = ext_clk_sel ? ext_fall : int_fall;
    rise     = ext_clk_sel ? ext_rise : int_rise;
    sck_o    = ext_clk_sel ? 1'b1 : int_sck;
  end

  sio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .div(clk_div),
    .sck(int_sck), .fall(int_fall), .rise(int_rise));

  sio_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .inhibit(inhibit),
    .ext_mode(ext_clk_sel), .fall(fall), .rise(rise), .sdi(sdi_s),
    .buf_tx(buf_tx), .buf_data(rx_data), .load(load), .done(done),
    .rx_byte(rx_byte), .busy(busy), .active(active), .sdo(sdo));

  sio_buf #(.DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_clk_sel), .inhibit(inhibit),
    .tx_valid(tx_valid), .tx_data(tx_data), .rx_ready(rx_ready),
    .load(load), .done(done), .rx_byte(rx_byte), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .buf_tx(buf_tx), .irq(irq),
    .overrun(overrun));

  // R2: completion pulse lasts one cycle
  assert_irq_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R2: each completion leaves a received byte offered
  assert_irq_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rx_valid);
endmodule

// File: tb/sim_sio_xcvr.sv
`timescale 1ns/1ps
module sim_sio_xcvr;
  logic clk = 0, rst_n = 0, start = 0, inhibit = 0, ext_sel = 0;
  logic [7:0] clk_div = 8'd3;
  logic tx_valid = 0, rx_ready = 0, sck_i = 1, sdi_e = 0, sdi_int = 0;
  logic [7:0] tx_data = 0;
  logic tx_ready, rx_valid, busy, irq, overrun, sck_o, sdo, sdi_w;
  logic [7:0] rx_data, sl_tx = 8'hFF, sl_rx = 0;
  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;
  assign sdi_w = ext_sel ? sdi_e : sdi_int;

  sio_xcvr u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .inhibit(inhibit),
    .ext_clk_sel(ext_sel), .clk_div(clk_div), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .busy(busy), .irq(irq),
    .overrun(overrun), .sck_i(sck_i), .sdi(sdi_w), .sck_o(sck_o), .sdo(sdo));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // slave model for internal-clock transfers
  always @(negedge sck_o) if (!ext_sel) begin
    sdi_int <= sl_tx[0];
    sl_tx   <= {1'b1, sl_tx[7:1]};
  end
  always @(posedge sck_o) if (!ext_sel) sl_rx <= {sdo, sl_rx[7:1]};

  // scoreboard monitor
  always @(negedge clk) if (rst_n && irq) begin
    if (exp_q.size() == 0) chk(0, "R2 unexpected byte", rx_data, 0);
    else begin
      automatic logic [7:0] e = exp_q.pop_front();
      chk(rx_data == e, "R2 received byte", rx_data, e);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_tx(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1; tx_data = b;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic rd_rx(output logic [7:0] d);
    @(negedge clk);
    rx_ready = 1; d = rx_data;
    @(posedge clk);
    @(negedge clk);
    rx_ready = 0;
  endtask

  task automatic wait_irq();
    while (!irq) @(negedge clk);
  endtask

  task automatic ext_byte(input logic [7:0] din, output logic [7:0] got, input bit meet);
    for (int i = 0; i < 8; i++) begin
      sck_i = 0; cyc(6);
      sdi_e = din[i]; cyc(6);
      got[i] = sdo;
      sck_i = 1;
      if (!(meet && i == 7)) cyc(8);
    end
  endtask

  initial begin
    #800000;
    chk(0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d, got;
    longint t0;
    bit seen;
    cyc(3);
    chk(!busy && !irq && !overrun && !rx_valid, "R1 flags after reset", {busy, irq, overrun, rx_valid}, 0);
    chk(tx_ready && sck_o && sdo, "R1 idle levels", {tx_ready, sck_o, sdo}, 3'b111);
    rst_n = 1; cyc(2);

    // internal mode byte 1
    wr_tx(8'h35); sl_tx = 8'hC6; exp_q.push_back(8'hC6);
    start = 1;
    @(negedge sck_o); t0 = $time;
    @(negedge sck_o);
    chk(($time - t0) == 32, "R3 sck period", int'($time - t0), 32);
    wait_irq();
    @(negedge clk);
    chk(!irq, "R2 irq one cycle", irq, 0);
    chk(sl_rx == 8'h35, "R2 sent byte LSB first", sl_rx, 8'h35);
    // stall
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      if (!sck_o || !busy) seen = 1;
      @(negedge clk);
    end
    chk(!seen, "R4 clock stalls high, busy held", seen, 0);
    chk(!tx_ready && rx_valid, "R4 buffer blocked", tx_ready, 0);
    tx_valid = 1; tx_data = 8'h99; cyc(3); tx_valid = 0;
    chk(rx_data == 8'hC6 && rx_valid, "R12 write refused while full", rx_data, 8'hC6);
    rd_rx(d);
    chk(d == 8'hC6, "R12 read hands over byte", d, 8'hC6);
    cyc(10);
    chk(sck_o && busy, "R4 still stalled until write", {sck_o, busy}, 2'b11);

    // byte 2: sdo hold, stop
    sl_tx = 8'h5A; exp_q.push_back(8'h5A);
    wr_tx(8'h01);
    chk(sdo == 1'b0, "R5 previous last bit held", sdo, 0);
    cyc(2);
    chk(sdo == 1'b0, "R5 held before first fall", sdo, 0);
    @(negedge sck_o); @(negedge clk);
    chk(sdo == 1'b1, "R5 first bit after fall", sdo, 1);
    start = 0; cyc(4);
    chk(busy, "R6 byte continues after stop", busy, 1);
    wait_irq();
    chk(!busy, "R6 busy clears at completion", busy, 0);
    chk(sl_rx == 8'h01, "R2 second byte sent", sl_rx, 8'h01);

    // mode change discards
    ext_sel = 1; cyc(1);
    chk(!rx_valid && tx_ready && !overrun, "R11 buffer discarded", {rx_valid, tx_ready}, 2'b01);
    ext_sel = 0; cyc(2);

    // inhibit
    wr_tx(8'h77); start = 1;
    @(negedge sck_o); @(negedge clk);
    inhibit = 1; @(negedge clk); inhibit = 0; start = 0;
    chk(!busy, "R7 busy clears at once", busy, 0);
    seen = 0;
    for (int k = 0; k < 40; k++) begin
      if (irq) seen = 1;
      @(negedge clk);
    end
    chk(!seen, "R7 no irq after abort", seen, 0);
    chk(tx_ready && !rx_valid && sck_o, "R7 buffer free, clock idle", {tx_ready, rx_valid, sck_o}, 3'b101);

    // external mode
    ext_sel = 1; cyc(4);
    wr_tx(8'h3C); exp_q.push_back(8'h96);
    start = 1; cyc(3);
    ext_byte(8'h96, got, 0);
    chk(got == 8'h3C, "R8 external byte sent", got, 8'h3C);
    chk(busy && rx_valid, "R8 no wait after byte", {busy, rx_valid}, 2'b11);
    exp_q.push_back(8'h0F);
    ext_byte(8'h0F, got, 0);
    chk(got == 8'hFF, "R8 fill when nothing written", got, 8'hFF);
    chk(overrun, "R9 overrun set", overrun, 1);
    rd_rx(d);
    chk(d == 8'h0F && !overrun, "R9 read clears overrun", {d, overrun}, {8'h0F, 1'b0});
    exp_q.push_back(8'h81);
    ext_byte(8'h81, got, 0);
    exp_q.push_back(8'h42);
    ext_byte(8'h42, got, 1);
    @(posedge clk); @(posedge clk); @(negedge clk);
    rx_ready = 1;
    chk(rx_data == 8'h81, "R10 old byte on handshake", rx_data, 8'h81);
    @(posedge clk); @(negedge clk);
    rx_ready = 0;
    chk(rx_valid && rx_data == 8'h42, "R10 new byte kept", rx_data, 8'h42);
    chk(!overrun, "R10 no overrun", overrun, 0);
    start = 0; cyc(2);
    chk(!busy, "R6 stop between bytes", busy, 0);
    rd_rx(d);
    cyc(4);
    chk(exp_q.size() == 0, "R2 all bytes seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule